// File: doc/BRIEF.md
# Legacy Peripheral Resource Decoder

This block turns three byte-wide configuration values (a function-enable byte, an address-map byte and a power/option byte) into the I/O resources of five legacy functions. The functions are a parallel port, two serial ports, a floppy controller and a disk controller. The disk controller has a primary window and an alternate window. For each function the block reports a 16-bit base I/O address and a 4-bit interrupt number, both derived combinationally from the configuration values.

The block also watches an I/O bus address qualified by a valid strobe. When the address falls inside the window of an enabled function, the matching chip-select is raised one clock later. Where windows overlap, a fixed priority ensures that at most one chip-select is active. The peripherals behind the chip-selects sit outside the block.

Top module: `legacy_res_decoder`

## Requirements
- R1: A chip-select is raised only when its function is enabled. The enable bits in `fn_enable_cfg` are: bit 0 parallel, bit 1 serial 0, bit 2 serial 1, bit 3 floppy, bit 6 disk controller.
- R2: The parallel base is set by `addr_map_cfg[1:0]`: code 0 gives 0x378, code 1 gives 0x3BC, code 2 gives 0x278, and code 3 gives 0x000.
- R3: The parallel IRQ is 5 for code 1 and 7 for code 2. For code 0 it is 7 when `power_cfg[3]` is 1 and 5 when it is 0.
- R4: Serial port n (n = 0 or 1) takes a 2-bit code from `addr_map_cfg[2n+3:2n+2]`. Code 0 gives 0x3F8 and code 1 gives 0x2F8. For codes 2 and 3, `addr_map_cfg[7:6]` (values 0..3) selects the base. Code 2 selects from 0x3E8, 0x338, 0x2E8, 0x220. Code 3 selects from 0x2E8, 0x238, 0x2E0, 0x228. Serial port n's base is on `ser_base[16n+15:16n]`.
- R5: A serial port's IRQ is 3 when its code is odd and 4 when it is even. Serial port n's IRQ is on `ser_irq[4n+3:4n]`.
- R6: The floppy base is 0x370 when `fn_enable_cfg[5]` is 1 and 0x3F0 otherwise. The floppy IRQ is always 6.
- R7: The disk primary base is 0x170 when `fn_enable_cfg[7]` is 1 and 0x1F0 otherwise. The alternate base is the primary base plus 0x206. The disk IRQ is always 14. A hit in either window selects the disk.
- R8: Window sizes are as follows:
  - serial, floppy and disk primary: 8 bytes;
  - parallel: 4 bytes at 0x3BC and 8 bytes at its other bases;
  - disk alternate: 2 bytes.

  An address hits a window when it is at least the base and below base plus size.
- R9: `chip_sel` changes only on the clock edge. It reflects the address and `bus_valid` sampled at the previous edge. It is all zero when `bus_valid` was 0, and all zero during and right after reset.
- R10: At most one `chip_sel` bit is set (bit 0 parallel, 1 serial 0, 2 serial 1, 3 floppy, 4 disk). When hits overlap, the lowest bit number wins.
- R11: With parallel code 3, the parallel port is never selected and its IRQ reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fn_enable_cfg | input | 8 | Function enables and base-select bits |
| addr_map_cfg | input | 8 | Parallel/serial address map codes |
| power_cfg | input | 8 | Option byte; bit 3 steers parallel IRQ |
| bus_addr | input | 16 | I/O bus address |
| bus_valid | input | 1 | Qualifies bus_addr |
| chip_sel | output | 5 | Registered one-hot chip-selects |
| par_base | output | 16 | Parallel base address |
| par_irq | output | 4 | Parallel IRQ number |
| ser_base | output | 32 | Serial bases, port n at [16n+15:16n] |
| ser_irq | output | 8 | Serial IRQs, port n at [4n+3:4n] |
| flp_base | output | 16 | Floppy base address |
| flp_irq | output | 4 | Floppy IRQ number |
| dsk_base | output | 16 | Disk primary base |
| dsk_alt_base | output | 16 | Disk alternate base |
| dsk_irq | output | 4 | Disk IRQ number |

## Verification
The base and IRQ outputs are purely combinational, so a wrong table entry or a wrong field slice shows up on the same cycle the configuration is applied. A wrong window size or a wrong priority shows up only on the chip-selects. It appears one edge after an address near a window edge, or inside an overlap region such as the floppy/disk-alternate area at 0x3F6, is presented. For this reason the stimulus concentrates addresses on each candidate base plus small offsets on either side of it.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
  localparam int unsigned NUM_FN  = 5;
  localparam int unsigned NUM_SER = 2;
  localparam int unsigned NUM_WIN = 6;
  localparam int unsigned LG_W    = 3;

  typedef enum logic [2:0] {
    FN_PAR = 3'd0,
    FN_SER0 = 3'd1,
    FN_SER1 = 3'd2,
    FN_FLP = 3'd3,
    FN_DSK = 3'd4
  } fn_idx_e;

  localparam logic [15:0] PAR_B0 = 16'h0378;
  localparam logic [15:0] PAR_B1 = 16'h03BC;
  localparam logic [15:0] PAR_B2 = 16'h0278;
  localparam logic [15:0] SER_P0 = 16'h03F8;
  localparam logic [15:0] SER_P1 = 16'h02F8;
  localparam logic [15:0] FLP_LO = 16'h03F0;
  localparam logic [15:0] FLP_HI = 16'h0370;
  localparam logic [15:0] DSK_LO = 16'h01F0;
  localparam logic [15:0] DSK_HI = 16'h0170;
  localparam logic [15:0] DSK_ALT_OFS = 16'h0206;
endpackage

// File: rtl/ldec_par_map.sv
module ldec_par_map #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IRQ_W  = 4
) (
  input  logic [1:0]        code_i,
  input  logic              irq_alt_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IRQ_W-1:0]  irq_o,
  output logic [2:0]        size_lg_o,
  output logic              present_o
);
  import ldec_pkg::*;

  always_comb begin
    base_o    = '0;
    irq_o     = '0;
    size_lg_o = 3'd3;
    present_o = 1'b1;
    unique case (code_i)
      2'd0: begin
        base_o = ADDR_W'(PAR_B0);
        irq_o  = irq_alt_i ? IRQ_W'(7) : IRQ_W'(5);
      end
      2'd1: begin
        base_o    = ADDR_W'(PAR_B1);
        irq_o     = IRQ_W'(5);
        size_lg_o = 3'd2;
      end
      2'd2: begin
        base_o = ADDR_W'(PAR_B2);
        irq_o  = IRQ_W'(7);
      end
      default: present_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldec_ser_map.sv
module ldec_ser_map #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IRQ_W  = 4
) (
  input  logic [1:0]        code_i,
  input  logic [1:0]        bank_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [IRQ_W-1:0]  irq_o
);
  import ldec_pkg::*;

  logic [15:0] alt_base;

  always_comb begin
    unique case ({code_i[0], bank_i})
      3'b000: alt_base = 16'h03E8;
      3'b001: alt_base = 16'h0338;
      3'b010: alt_base = 16'h02E8;
      3'b011: alt_base = 16'h0220;
      3'b100: alt_base = 16'h02E8;
      3'b101: alt_base = 16'h0238;
      3'b110: alt_base = 16'h02E0;
      default: alt_base = 16'h0228;
    endcase
  end

  always_comb begin
    unique case (code_i)
      2'd0:    base_o = ADDR_W'(SER_P0);
      2'd1:    base_o = ADDR_W'(SER_P1);
      default: base_o = ADDR_W'(alt_base);
    endcase
    irq_o = code_i[0] ? IRQ_W'(3) : IRQ_W'(4);
  end
endmodule

// File: rtl/ldec_win_match.sv
module ldec_win_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LG_W   = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LG_W-1:0]   size_lg_i,
  input  logic              en_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] mask;

  always_comb begin
    mask  = ~((ADDR_W'(1) << size_lg_i) - ADDR_W'(1));
    hit_o = en_i && ((addr_i & mask) == (base_i & mask));
  end
endmodule

// File: rtl/legacy_res_decoder.sv
module legacy_res_decoder #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IRQ_W  = 4,
  parameter int unsigned CFG_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     fn_enable_cfg,
  input  logic [CFG_W-1:0]     addr_map_cfg,
  input  logic [CFG_W-1:0]     power_cfg,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_valid,
  output logic [4:0]           chip_sel,
  output logic [ADDR_W-1:0]    par_base,
  output logic [IRQ_W-1:0]     par_irq,
  output logic [2*ADDR_W-1:0]  ser_base,
  output logic [2*IRQ_W-1:0]   ser_irq,
  output logic [ADDR_W-1:0]    flp_base,
  output logic [IRQ_W-1:0]     flp_irq,
  output logic [ADDR_W-1:0]    dsk_base,
  output logic [ADDR_W-1:0]    dsk_alt_base,
  output logic [IRQ_W-1:0]     dsk_irq
);
  import ldec_pkg::*;

  localparam int unsigned SER_EN_LSB = 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [2:0] par_lg;
  logic       par_present;

  ldec_par_map #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_par (
    .code_i    (addr_map_cfg[1:0]),
    .irq_alt_i (power_cfg[3]),
    .base_o    (par_base),
    .irq_o     (par_irq),
    .size_lg_o (par_lg),
    .present_o (par_present)
  );

  logic [ADDR_W-1:0] ser_b [NUM_SER];

  for (genvar s = 0; s < NUM_SER; s++) begin : g_ser
    ldec_ser_map #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W)) u_ser (
      .code_i (addr_map_cfg[2*s+3 -: 2]),
      .bank_i (addr_map_cfg[7:6]),
      .base_o (ser_b[s]),
      .irq_o  (ser_irq[s*IRQ_W +: IRQ_W])
    );
    assign ser_base[s*ADDR_W +: ADDR_W] = ser_b[s];
  end

  always_comb begin
    flp_base     = fn_enable_cfg[5] ? ADDR_W'(FLP_HI) : ADDR_W'(FLP_LO);
    flp_irq      = IRQ_W'(6);
    dsk_base     = fn_enable_cfg[7] ? ADDR_W'(DSK_HI) : ADDR_W'(DSK_LO);
    dsk_alt_base = dsk_base + ADDR_W'(DSK_ALT_OFS);
    dsk_irq      = IRQ_W'(14);
  end

  // window table: par, ser0, ser1, flp, dsk primary, dsk alternate
  logic [ADDR_W-1:0] win_base [NUM_WIN];
  logic [LG_W-1:0]   win_lg   [NUM_WIN];
  logic [NUM_WIN-1:0] win_en, win_hit;

  always_comb begin
    win_base[0] = par_base;
    win_lg[0]   = par_lg;
    win_en[0]   = fn_enable_cfg[0] && par_present;
    for (int s = 0; s < NUM_SER; s++) begin
      win_base[1+s] = ser_b[s];
      win_lg[1+s]   = 3'd3;
      win_en[1+s]   = fn_enable_cfg[SER_EN_LSB+s];
    end
    win_base[3] = flp_base;
    win_lg[3]   = 3'd3;
    win_en[3]   = fn_enable_cfg[3];
    win_base[4] = dsk_base;
    win_lg[4]   = 3'd3;
    win_en[4]   = fn_enable_cfg[6];
    win_base[5] = dsk_alt_base;
    win_lg[5]   = 3'd1;
    win_en[5]   = fn_enable_cfg[6];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ldec_win_match #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_match (
      .addr_i    (bus_addr),
      .base_i    (win_base[w]),
      .size_lg_i (win_lg[w]),
      .en_i      (win_en[w]),
      .hit_o     (win_hit[w])
    );
  end

  // priority pick and chip-select register
  logic [NUM_FN-1:0] fn_hit, cs_next, cs_q;

  always_comb begin
    fn_hit  = {win_hit[4] | win_hit[5], win_hit[3:0]};
    cs_next = '0;
    if (bus_valid) begin
      for (int i = NUM_FN-1; i >= 0; i--) begin
        if (fn_hit[i]) cs_next = NUM_FN'(1) << i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
    end else if (!rst_sync) begin
      cs_q <= '0;
    end else begin
      cs_q <= cs_next;
    end
  end

  assign chip_sel = cs_q;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(chip_sel)); // R10
  AST_CS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_sync)
    !$past(bus_valid) |-> chip_sel == '0); // R9
  AST_CS_PAR_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync)
    chip_sel[FN_PAR] |-> ($past(fn_enable_cfg[0]) && $past(addr_map_cfg[1:0]) != 2'd3)); // R11
  AST_CS_DSK_ENABLED: assert property (@(posedge clk) disable iff (!rst_sync)
    chip_sel[FN_DSK] |-> $past(fn_enable_cfg[6])); // R1
  AST_SER_IRQ_RANGE: assert property (@(posedge clk) disable iff (!rst_sync)
    (ser_irq[IRQ_W-1:0] == IRQ_W'(3)) || (ser_irq[IRQ_W-1:0] == IRQ_W'(4))); // R5
endmodule

// File: tb/legacy_res_decoder_test.sv
`timescale 1ns/1ps
module legacy_res_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  fe = '0, fa = '0, pw = '0;
  logic [15:0] addr = '0;
  logic        valid = 1'b0;
  logic [4:0]  chip_sel;
  logic [15:0] par_base, flp_base, dsk_base, dsk_alt_base;
  logic [3:0]  par_irq, flp_irq, dsk_irq;
  logic [31:0] ser_base;
  logic [7:0]  ser_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [4:0] exp_cs = '0;

  always #4 clk = ~clk;

  legacy_res_decoder uut (
    .clk(clk), .rst_n(rst_n), .fn_enable_cfg(fe), .addr_map_cfg(fa),
    .power_cfg(pw), .bus_addr(addr), .bus_valid(valid), .chip_sel(chip_sel),
    .par_base(par_base), .par_irq(par_irq), .ser_base(ser_base),
    .ser_irq(ser_irq), .flp_base(flp_base), .flp_irq(flp_irq),
    .dsk_base(dsk_base), .dsk_alt_base(dsk_alt_base), .dsk_irq(dsk_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int m_par_base(input int code);
    case (code)
      0: return 'h378;
      1: return 'h3BC;
      2: return 'h278;
      default: return 0;
    endcase
  endfunction

  function automatic int m_par_irq(input int code, input bit p3);
    case (code)
      0: return p3 ? 7 : 5;
      1: return 5;
      2: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int m_ser_base(input int code, input int bank);
    int t2[4] = '{'h3E8, 'h338, 'h2E8, 'h220};
    int t3[4] = '{'h2E8, 'h238, 'h2E0, 'h228};
    if (code == 0) return 'h3F8;
    if (code == 1) return 'h2F8;
    return (code == 2) ? t2[bank] : t3[bank];
  endfunction

  function automatic bit inwin(input int a, input int b, input int sz);
    return (a >= b) && (a < b + sz);
  endfunction

  function automatic logic [4:0] m_cs(input logic [7:0] e, input logic [7:0] m,
                                      input int a, input bit v);
    bit h[5];
    int pc, db;
    if (!v) return 5'd0;
    pc = int'(m[1:0]);
    db = e[7] ? 'h170 : 'h1F0;
    h[0] = e[0] && pc != 3 && inwin(a, m_par_base(pc), pc == 1 ? 4 : 8);
    for (int n = 0; n < 2; n++)
      h[1+n] = e[1+n] && inwin(a, m_ser_base(int'((m >> (2*n+2)) & 8'h3), int'(m[7:6])), 8);
    h[3] = e[3] && inwin(a, e[5] ? 'h370 : 'h3F0, 8);
    h[4] = e[6] && (inwin(a, db, 8) || inwin(a, db + 'h206, 2));
    for (int i = 0; i < 5; i++) if (h[i]) return 5'(1 << i);
    return 5'd0;
  endfunction

  // one cycle: check registered output from the previous stimulus, drive new
  task automatic step(input logic [7:0] e, input logic [7:0] m, input logic [7:0] p,
                      input logic [15:0] a, input bit v);
    int pc, db;
    @(negedge clk);
    chk(chip_sel == exp_cs, "R9/R10/R8/R1 chip_sel", int'(chip_sel), int'(exp_cs));
    fe = e; fa = m; pw = p; addr = a; valid = v;
    #1;
    pc = int'(m[1:0]);
    db = e[7] ? 'h170 : 'h1F0;
    chk(int'(par_base) == m_par_base(pc), "R2 par_base", int'(par_base), m_par_base(pc));
    chk(int'(par_irq) == m_par_irq(pc, p[3]), "R3/R11 par_irq", int'(par_irq), m_par_irq(pc, p[3]));
    for (int n = 0; n < 2; n++) begin
      int c = int'((m >> (2*n+2)) & 8'h3);
      int eb = m_ser_base(c, int'(m[7:6]));
      int got = int'(ser_base[16*n +: 16]);
      int gi = int'(ser_irq[4*n +: 4]);
      chk(got == eb, "R4 ser_base", got, eb);
      chk(gi == ((c % 2) ? 3 : 4), "R5 ser_irq", gi, (c % 2) ? 3 : 4);
    end
    chk(int'(flp_base) == (e[5] ? 'h370 : 'h3F0), "R6 flp_base", int'(flp_base), e[5] ? 'h370 : 'h3F0);
    chk(flp_irq == 4'd6, "R6 flp_irq", int'(flp_irq), 6);
    chk(int'(dsk_base) == db, "R7 dsk_base", int'(dsk_base), db);
    chk(int'(dsk_alt_base) == db + 'h206, "R7 dsk_alt_base", int'(dsk_alt_base), db + 'h206);
    chk(dsk_irq == 4'd14, "R7 dsk_irq", int'(dsk_irq), 14);
    exp_cs = m_cs(e, m, int'(a), v);
  endtask

  function automatic logic [15:0] pick_addr(input int k);
    case (k % 16)
      0: return 16'h0378;  1: return 16'h03BC;  2: return 16'h0278;
      3: return 16'h03F8;  4: return 16'h02F8;  5: return 16'h03E8;
      6: return 16'h0338;  7: return 16'h0220;  8: return 16'h0238;
      9: return 16'h02E0; 10: return 16'h0228; 11: return 16'h0370;
     12: return 16'h03F0; 13: return 16'h01F0; 14: return 16'h0170;
      default: return 16'h03F6;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(chip_sel == 5'd0, "R9 reset chip_sel", int'(chip_sel), 0);
    rst_n = 1'b1;
    repeat (3) step(8'h00, 8'h00, 8'h00, 16'h0000, 1'b0);
    // R2 R3 R11: each parallel code, option bit both ways
    for (int c = 0; c < 4; c++) begin
      step(8'h01, 8'(c), 8'h00, 16'h0378, 1'b1);
      step(8'h01, 8'(c), 8'h08, 16'h03BF, 1'b1);
      step(8'h01, 8'(c), 8'h08, 16'h03C0, 1'b1); // R8 just past 4-byte window
      step(8'h01, 8'(c), 8'h00, 16'h027F, 1'b1);
    end
    // R4 R5: every serial code and bank
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 4; c++)
        step(8'h06, 8'((b << 6) | (c << 2) | ((3 - c) << 4)), 8'h00,
             16'(m_ser_base(c, b) + 7), 1'b1);
    // R10: both serial ports on 0x3F8, floppy vs disk alternate overlap
    step(8'h06, 8'h00, 8'h00, 16'h03F9, 1'b1);
    step(8'h48, 8'h00, 8'h00, 16'h03F6, 1'b1);
    step(8'h40, 8'h00, 8'h00, 16'h03F7, 1'b1);
    step(8'h40, 8'h00, 8'h00, 16'h03F8, 1'b1); // R8 alternate is 2 bytes
    step(8'hC0, 8'h00, 8'h00, 16'h0376, 1'b1); // R7 alternate at 0x376
    step(8'h28, 8'h00, 8'h00, 16'h0377, 1'b1); // R6 floppy high base
    // R1: disabled functions never selected; R9 no valid
    step(8'h00, 8'h00, 8'h00, 16'h03F8, 1'b1);
    step(8'hFF, 8'h00, 8'h00, 16'h0378, 1'b0);
    // random sweep near candidate bases
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      a = ($urandom % 8 == 0) ? 16'($urandom) :
          16'(int'(pick_addr(int'($urandom))) + int'($urandom % 12) - 2);
      step(8'($urandom), 8'($urandom), 8'($urandom), a, ($urandom % 5) != 0);
    end
    step(8'h00, 8'h00, 8'h00, 16'h0000, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule